// File: doc/BRIEF.md
# Received Packet Acceptance Filter

This block sits between a packet decoder and the host serial path of a radio node. For every received packet it captures the sender's 7-bit group tag and the sender's network role from the header, stores the payload bytes locally, and takes the end-of-packet CRC verdict from the decoder. When the packet ends, it decides whether to release the stored bytes to the host or to discard them.

A packet is released only when three rules all pass. The sender's group must equal the local group. The topology rule must allow it: a node configured as a slave ignores other slaves. If the CRC check is switched on, the CRC-good flag must be set. Rejected packets leave no trace on the output. Three saturating counters record the rejections, and each rejected packet is charged to exactly one cause. Local configuration is held in three small registers that are written through a simple write strobe.

Top module: `rx_accept_filter`

## Requirements
- R1: After reset the local group is 0, the local role is normal, the CRC check is enabled, all three drop counters read 0 and `out_valid` is low.
- R2: An accepted packet's bytes appear on `out_data` in arrival order, one per cycle with `out_valid` high, starting only after `eop_valid`. `out_last` is high with the final byte.
- R3: A packet whose header group differs from the local group produces no output and increments `drop_group`.
- R4: When the local role is slave, a packet from a slave sender (`hdr_slave`=1) produces no output and increments `drop_topo`.
- R5: A normal-role node accepts packets from both slave and normal senders. A slave-role node accepts packets from normal senders.
- R6: With the CRC check enabled, a packet that ends with `eop_crc_good`=0 produces no output and increments `drop_crc`.
- R7: With the CRC check disabled, `eop_crc_good` is ignored: a packet ending with it low is still released.
- R8: A packet that breaks several rules is charged to one counter only. The order of precedence is group, then topology, then CRC.
- R9: Each drop counter saturates at its all-ones value and does not wrap.
- R10: Configuration writes use `cfg_addr`. Address 0 sets the local group from `cfg_wdata[6:0]`. Address 1 sets the role, where 0x00 means slave and 0x01 means normal. Address 2 sets the CRC check, where 0x01 means on and 0x00 means off.
- R11: A new header discards any bytes received since the previous header, so only the bytes after the last header are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| hdr_valid | input | 1 | Header strobe; starts a packet |
| hdr_group | input | 7 | Sender group tag |
| hdr_slave | input | 1 | Sender role; 1 means slave |
| in_valid | input | 1 | Payload byte strobe |
| in_data | input | 8 | Payload byte |
| eop_valid | input | 1 | End-of-packet strobe |
| eop_crc_good | input | 1 | CRC verdict; valid with `eop_valid` |
| out_valid | output | 1 | Released byte strobe |
| out_data | output | 8 | Released byte |
| out_last | output | 1 | Final released byte of a packet |
| drop_group | output | CNT_W | Drops caused by group mismatch |
| drop_topo | output | CNT_W | Drops caused by the slave-to-slave rule |
| drop_crc | output | CNT_W | Drops caused by a CRC failure |

## Verification
The assertions assume that the decoder never sends a header, payload byte or end strobe while a released packet is still draining. They also assume that payload bytes and the end strobe never share a cycle, and that a packet carries at most DEPTH bytes. The stimulus holds to these assumptions. Each packet is driven as a header, then its bytes, then the end strobe on separate cycles. The bench then waits longer than the packet length before starting the next one, and no payload in the run is longer than the buffer.

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             hdr_valid,
  input  logic [6:0]       hdr_group,
  input  logic             hdr_slave,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             eop_valid,
  input  logic             eop_crc_good,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [CNT_W-1:0] drop_group,
  output logic [CNT_W-1:0] drop_topo,
  output logic [CNT_W-1:0] drop_crc
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [6:0]    my_group;
  logic          my_normal, crc_on;
  logic [6:0]    pkt_group;
  logic          pkt_slave;
  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] wr_cnt, rd_idx;
  logic          draining;

  wire grp_bad  = pkt_group != my_group;
  wire topo_bad = !my_normal && pkt_slave;
  wire crc_bad  = crc_on && !eop_crc_good;
  wire accept   = !grp_bad && !topo_bad && !crc_bad;
  wire verdict  = eop_valid && !draining;

  assign out_valid = draining;
  assign out_data  = mem[rd_idx[AW-1:0]];
  assign out_last  = draining && (rd_idx == wr_cnt - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      my_group  <= '0;
      my_normal <= 1'b1;
      crc_on    <= 1'b1;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: my_group  <= cfg_wdata[6:0];
        2'd1: my_normal <= cfg_wdata[0];
        2'd2: crc_on    <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_group <= '0;
      pkt_slave <= 1'b0;
      wr_cnt    <= '0;
      rd_idx    <= '0;
      draining  <= 1'b0;
    end else if (draining) begin
      if (out_last) begin
        draining <= 1'b0;
        wr_cnt   <= '0;
      end else
        rd_idx <= rd_idx + LW'(1);
    end else begin
      if (hdr_valid) begin
        pkt_group <= hdr_group;
        pkt_slave <= hdr_slave;
        wr_cnt    <= '0;
      end else if (in_valid && wr_cnt < LW'(DEPTH))
        wr_cnt <= wr_cnt + LW'(1);
      if (verdict) begin
        rd_idx <= '0;
        if (accept && wr_cnt != '0) draining <= 1'b1;
        else wr_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk)
    if (!draining && !hdr_valid && in_valid && wr_cnt < LW'(DEPTH))
      mem[wr_cnt[AW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_group <= '0;
      drop_topo  <= '0;
      drop_crc   <= '0;
    end else if (verdict) begin
      if (grp_bad) begin
        if (drop_group != CMAX) drop_group <= drop_group + CNT_W'(1);
      end else if (topo_bad) begin
        if (drop_topo != CMAX) drop_topo <= drop_topo + CNT_W'(1);
      end else if (crc_bad) begin
        if (drop_crc != CMAX) drop_crc <= drop_crc + CNT_W'(1);
      end
    end
  end

  a_r2_start_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(eop_valid));
  a_r2_last_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);
  a_r4_slave_blocks_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict && !my_normal && pkt_slave) |=> !out_valid);
  a_r6_crc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict && crc_on && !eop_crc_good) |=> !out_valid);
  a_r8_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({drop_group != $past(drop_group), drop_topo != $past(drop_topo),
                drop_crc != $past(drop_crc)}) <= 1);
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_group >= $past(drop_group)) && (drop_topo >= $past(drop_topo)) &&
    (drop_crc >= $past(drop_crc)));
endmodule

// File: tb/rx_accept_filter_test.sv
module rx_accept_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 3;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
  logic hdr_valid = 0; logic [6:0] hdr_group = 0; logic hdr_slave = 0;
  logic in_valid = 0; logic [7:0] in_data = 0;
  logic eop_valid = 0, eop_crc_good = 0;
  logic out_valid, out_last; logic [7:0] out_data;
  logic [CW-1:0] drop_group, drop_topo, drop_crc;

  int checks = 0, errors = 0;
  logic [8:0] exp_q[$];
  logic [6:0] m_group = 0; logic m_normal = 1, m_crc = 1;
  int e_grp = 0, e_topo = 0, e_crc = 0;

  rx_accept_filter #(.DEPTH(DEPTH), .CNT_W(CW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && out_valid) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R2 unexpected byte: actual %0h expected none", out_data);
    end else begin
      logic [8:0] e;
      e = exp_q.pop_front();
      if ({out_last, out_data} != e) begin
        errors++;
        $display("FAIL R2 byte/last: actual %0h expected %0h", {out_last, out_data}, e);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a == 0) m_group = d[6:0];
    if (a == 1) m_normal = d[0];
    if (a == 2) m_crc = d[0];
  endtask

  task automatic send(input string tag, input logic [6:0] g, input logic s,
                      input int n, input logic [7:0] seed, input logic good,
                      input int junk);
    bit acc;
    @(negedge clk); hdr_valid = 1; hdr_group = g; hdr_slave = s;
    @(negedge clk); hdr_valid = 0;
    for (int i = 0; i < junk; i++) begin
      in_valid = 1; in_data = 8'hEE; @(negedge clk);
    end
    in_valid = 0;
    if (junk > 0) begin
      hdr_valid = 1; @(negedge clk); hdr_valid = 0;
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = seed + 8'(i * 7); @(negedge clk);
    end
    in_valid = 0;
    acc = 0;
    if (g != m_group) begin if (e_grp < 7) e_grp++; end
    else if (!m_normal && s) begin if (e_topo < 7) e_topo++; end
    else if (m_crc && !good) begin if (e_crc < 7) e_crc++; end
    else acc = 1;
    if (acc) for (int i = 0; i < n; i++)
      exp_q.push_back({(i == n - 1), seed + 8'(i * 7)});
    eop_valid = 1; eop_crc_good = good;
    @(negedge clk); eop_valid = 0; eop_crc_good = 0;
    repeat (n + 3) @(negedge clk);
    check_eq({tag, " pending bytes"}, exp_q.size(), 0);
    check_eq({tag, " drop_group"}, int'(drop_group), e_grp);
    check_eq({tag, " drop_topo"}, int'(drop_topo), e_topo);
    check_eq({tag, " drop_crc"}, int'(drop_crc), e_crc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_eq("R1 out_valid", int'(out_valid), 0);
    check_eq("R1 drop_group", int'(drop_group), 0);
    check_eq("R1 drop_topo", int'(drop_topo), 0);
    check_eq("R1 drop_crc", int'(drop_crc), 0);
    send("R1 R2 default accept", 7'd0, 0, 5, 8'h10, 1, 0);
    send("R3 group mismatch", 7'd5, 0, 4, 8'h20, 1, 0);
    cfg_write(2'd0, 8'hC5);
    send("R10 group write", 7'h45, 0, 3, 8'h30, 1, 0);
    send("R5 normal hears slave", 7'h45, 1, 6, 8'h40, 1, 0);
    send("R6 crc bad", 7'h45, 0, 4, 8'h50, 0, 0);
    cfg_write(2'd1, 8'h00);
    send("R4 slave to slave", 7'h45, 1, 4, 8'h60, 1, 0);
    send("R5 slave hears normal", 7'h45, 0, 2, 8'h70, 1, 0);
    send("R8 all rules broken", 7'h01, 1, 3, 8'h80, 0, 0);
    send("R8 topo and crc", 7'h45, 1, 3, 8'h90, 0, 0);
    cfg_write(2'd2, 8'h00);
    send("R7 crc ignored", 7'h45, 0, 5, 8'hA0, 0, 0);
    cfg_write(2'd2, 8'h01);
    send("R10 crc back on", 7'h45, 0, 2, 8'hB0, 0, 0);
    cfg_write(2'd1, 8'h01);
    send("R11 header restart", 7'h45, 1, 4, 8'hC0, 1, 3);
    send("R2 full buffer", 7'h45, 0, DEPTH, 8'hD0, 1, 0);
    for (int k = 0; k < 8; k++) send("R9 saturate", 7'h00, 0, 1, 8'hE0, 1, 0);
    check_eq("R9 drop_group held at max", int'(drop_group), 7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule